// File: doc/BRIEF.md
# Timed Sleep Entry/Exit Sequencer

This block supervises the power mode of a processor. It holds the processor in one of three resting modes: Run, where everything is clocked and powered; Idle, where only the processor clock is gated while the I/O logic stays powered; and Sleep, where almost everything is shut down. It moves between these modes in response to an idle request, a sleep request and a wake event.

Idle gates only the clock distribution, and clock generation keeps running. Idle is therefore entered and left in a single cycle. Sleep is entered and left through fixed timed sequences. Entry runs three phases: state flush, processor reset and clock shutdown. Exit runs three more: supply ramp, clock stabilisation and boot. Each phase lasts a number of reference-clock cycles set by a parameter. A one-hot phase output names the current step. A busy flag covers every phase. The block reports active (Run-level) power for the whole of each sequence, because a transition draws as much as Run does.

A wake event that arrives while the block is still entering Sleep is remembered. The block reaches Sleep for a single cycle and then starts the exit sequence at once. Mode requests that arrive while a sequence is in progress are dropped.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous reset, and in Run, the mode output is 0 and the status outputs are: cpu_clk_en=1, io_pwr_good=1, active_pwr=1, busy=0, phase_oh=0. The mode codes are Run=0, Idle=1, Sleep=2 and in-sequence=3.
- R2: In Run, req_idle moves the block to Idle (mode 1) on the next edge, with cpu_clk_en=0, io_pwr_good=1 and active_pwr=0. If req_sleep and req_idle are both high, req_sleep wins.
- R3: In Idle, wake returns the block to Run on the next edge with no intermediate phase, and wake takes priority over req_sleep. In Run, wake has no effect.
- R4: req_sleep in Run or Idle starts the entry sequence: flush for FLUSH_CYC cycles, then processor reset for PRST_CYC cycles, then clock-off for COFF_CYC cycles, then Sleep (mode 2).
- R5: In Sleep the outputs are cpu_clk_en=0, io_pwr_good=0 and active_pwr=0, and the block stays in Sleep for as long as no wake arrives.
- R6: wake in Sleep starts the exit sequence: supply ramp for RAMP_CYC cycles, then clock stabilisation for STAB_CYC cycles, then boot for BOOT_CYC cycles, then Run.
- R7: In every phase, mode is 3, busy=1 and active_pwr=1, and phase_oh is one-hot with bit 0 for flush, bit 1 for reset, bit 2 for clock-off, bit 3 for ramp, bit 4 for stabilise and bit 5 for boot. Outside the phases, phase_oh is 0 and busy is 0.
- R8: req_idle and req_sleep are ignored while busy is high, so the phase order and the phase lengths are unchanged.
- R9: A wake that arrives during the entry sequence is held. After clock-off, the block spends exactly one cycle in Sleep and then enters the supply-ramp phase. The held wake is consumed, so a later Sleep lasts until a new wake arrives.
- R10: cpu_clk_en is 1 in the flush, reset and boot phases and 0 in the clock-off, ramp and stabilise phases. io_pwr_good is 0 only in Sleep and in the ramp phase.
- R11: Reset asserted in the middle of a sequence returns the block to Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times every phase |
| rst_n | input | 1 | Synchronous active-low reset |
| req_idle | input | 1 | Request to gate the processor clock (Idle) |
| req_sleep | input | 1 | Request to start the Sleep entry sequence |
| wake | input | 1 | Wake event for leaving Idle or Sleep |
| mode | output | 2 | 0 Run, 1 Idle, 2 Sleep, 3 in a sequence |
| phase_oh | output | 6 | One-hot code of the current phase, 0 outside a sequence |
| busy | output | 1 | High during every sequence phase |
| cpu_clk_en | output | 1 | Enable for the processor clock |
| io_pwr_good | output | 1 | I/O supply reported good |
| active_pwr | output | 1 | Block is drawing Run-level power |

## Verification
The bench shrinks every phase to a few cycles and follows each phase cycle by cycle. A timer that is off by one shows up as a phase that lasts one cycle too long or one cycle too short. Requests are injected in the middle of a phase; a design that accepted them would jump to Idle or restart the flush phase. A wake sent during entry must appear as a single Sleep cycle followed by the ramp phase. A design that dropped the held wake would stay asleep, and a design that kept it would bounce straight out of the next Sleep. Priority collisions (sleep against idle in Run, wake against sleep in Idle) and a reset in the middle of a sequence are driven directly.

// File: rtl/pms_pkg.sv
// Package: shared state encoding, mode codes and phase indices for the
// power-mode sequencer. Assumes the six phase states are contiguous in
// the state enum so that phase decode can be generated by index.
package pms_pkg;

    localparam int NUM_PHASES = 6;

    // Phases occupy ST_FLUSH..ST_BOOT in order; PH_BASE is the first one.
    typedef enum logic [3:0] {
        ST_RUN   = 4'd0,
        ST_IDLE  = 4'd1,
        ST_SLEEP = 4'd2,
        ST_FLUSH = 4'd3,
        ST_PRST  = 4'd4,
        ST_COFF  = 4'd5,
        ST_RAMP  = 4'd6,
        ST_STAB  = 4'd7,
        ST_BOOT  = 4'd8
    } pms_state_e;

    localparam int PH_BASE = 3;

    localparam logic [1:0] MODE_RUN   = 2'd0;
    localparam logic [1:0] MODE_IDLE  = 2'd1;
    localparam logic [1:0] MODE_SLEEP = 2'd2;
    localparam logic [1:0] MODE_TRANS = 2'd3;

    typedef struct packed {
        logic busy;
        logic clk_en;
        logic io_good;
        logic active;
    } pms_status_t;

endpackage

// File: rtl/pms_phase_timer.sv
// Module: single down-counter shared by all timed phases. Assumes the
// controller loads (length-1) on the cycle it enters a phase; done is
// high during the last cycle of that phase.
module pms_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    // Purpose: load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Purpose: flag the final cycle of the running phase.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/pms_wake_hold.sv
// Module: remembers a wake event seen while the entry sequence runs.
// Assumes clr is pulsed when the controller leaves Sleep for the ramp.
module pms_wake_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic in_entry,
    input  logic clr,
    output logic held
);

    // Purpose: set on wake during entry, clear once the exit starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 1'b0;
        else if (clr)
            held <= 1'b0;
        else if (in_entry && wake)
            held <= 1'b1;
    end

endmodule

// File: rtl/pms_ctrl.sv
// Module: mode and phase state machine. Chooses the next state from the
// requests and the phase timer, and loads the timer with the length of
// each phase it enters. Assumes every phase length is at least 1 cycle
// and fits in CW bits.
module pms_ctrl
    import pms_pkg::*;
#(
    parameter int CW        = 8,
    parameter int FLUSH_CYC = 4,
    parameter int PRST_CYC  = 4,
    parameter int COFF_CYC  = 4,
    parameter int RAMP_CYC  = 4,
    parameter int STAB_CYC  = 4,
    parameter int BOOT_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_idle,
    input  logic          req_sleep,
    input  logic          wake,
    input  logic          wake_held,
    input  logic          tmr_done,
    output pms_state_e    state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          in_entry,
    output logic          held_clr
);

    localparam logic [CW-1:0] LD_FLUSH = CW'(FLUSH_CYC - 1);
    localparam logic [CW-1:0] LD_PRST  = CW'(PRST_CYC - 1);
    localparam logic [CW-1:0] LD_COFF  = CW'(COFF_CYC - 1);
    localparam logic [CW-1:0] LD_RAMP  = CW'(RAMP_CYC - 1);
    localparam logic [CW-1:0] LD_STAB  = CW'(STAB_CYC - 1);
    localparam logic [CW-1:0] LD_BOOT  = CW'(BOOT_CYC - 1);

    pms_state_e nxt;

    // Purpose: next-state choice; requests only matter in Run, Idle and Sleep.
    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:   if (req_sleep) nxt = ST_FLUSH;
                      else if (req_idle) nxt = ST_IDLE;
            ST_IDLE:  if (wake) nxt = ST_RUN;
                      else if (req_sleep) nxt = ST_FLUSH;
            ST_SLEEP: if (wake || wake_held) nxt = ST_RAMP;
            ST_FLUSH: if (tmr_done) nxt = ST_PRST;
            ST_PRST:  if (tmr_done) nxt = ST_COFF;
            ST_COFF:  if (tmr_done) nxt = ST_SLEEP;
            ST_RAMP:  if (tmr_done) nxt = ST_STAB;
            ST_STAB:  if (tmr_done) nxt = ST_BOOT;
            ST_BOOT:  if (tmr_done) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // Purpose: pick the timer reload for the state being entered.
    always_comb begin
        case (nxt)
            ST_FLUSH: tmr_val = LD_FLUSH;
            ST_PRST:  tmr_val = LD_PRST;
            ST_COFF:  tmr_val = LD_COFF;
            ST_RAMP:  tmr_val = LD_RAMP;
            ST_STAB:  tmr_val = LD_STAB;
            ST_BOOT:  tmr_val = LD_BOOT;
            default:  tmr_val = '0;
        endcase
        tmr_load = (nxt != state);
    end

    // Purpose: strobes for the wake holder.
    always_comb begin
        in_entry = (state == ST_FLUSH) || (state == ST_PRST) || (state == ST_COFF);
        held_clr = (state == ST_SLEEP) && (nxt == ST_RAMP);
    end

    // Purpose: state register, Run after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= nxt;
    end

endmodule

// File: rtl/pms_out_decode.sv
// Module: turns the controller state into the mode code, the one-hot
// phase vector and the clock/power status flags. Purely combinational.
module pms_out_decode
    import pms_pkg::*;
(
    input  pms_state_e             state,
    output logic [1:0]             mode,
    output logic [NUM_PHASES-1:0]  phase_oh,
    output pms_status_t            status
);

    // One decoder bit per phase, indexed from the first phase state.
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        assign phase_oh[g] = (state == pms_state_e'(PH_BASE + g));
    end

    // Purpose: mode code and status flags per state.
    always_comb begin
        case (state)
            ST_RUN:   begin mode = MODE_RUN;   status = '{busy:1'b0, clk_en:1'b1, io_good:1'b1, active:1'b1}; end
            ST_IDLE:  begin mode = MODE_IDLE;  status = '{busy:1'b0, clk_en:1'b0, io_good:1'b1, active:1'b0}; end
            ST_SLEEP: begin mode = MODE_SLEEP; status = '{busy:1'b0, clk_en:1'b0, io_good:1'b0, active:1'b0}; end
            ST_FLUSH,
            ST_PRST,
            ST_BOOT:  begin mode = MODE_TRANS; status = '{busy:1'b1, clk_en:1'b1, io_good:1'b1, active:1'b1}; end
            ST_COFF,
            ST_STAB:  begin mode = MODE_TRANS; status = '{busy:1'b1, clk_en:1'b0, io_good:1'b1, active:1'b1}; end
            ST_RAMP:  begin mode = MODE_TRANS; status = '{busy:1'b1, clk_en:1'b0, io_good:1'b0, active:1'b1}; end
            default:  begin mode = MODE_RUN;   status = '{busy:1'b0, clk_en:1'b1, io_good:1'b1, active:1'b1}; end
        endcase
    end

endmodule

// File: rtl/pwr_mode_seq.sv
// Module: top of the power-mode sequencer. Connects the controller, the
// shared phase timer, the wake holder and the output decoder. Phase
// lengths are reference-clock cycle counts (defaults assume 100 MHz:
// 30 us entry phases, 10 ms ramp, 150 ms stabilise, short boot).
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int FLUSH_CYC = 3000,
    parameter int PRST_CYC  = 3000,
    parameter int COFF_CYC  = 3000,
    parameter int RAMP_CYC  = 1000000,
    parameter int STAB_CYC  = 15000000,
    parameter int BOOT_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_idle,
    input  logic       req_sleep,
    input  logic       wake,
    output logic [1:0] mode,
    output logic [5:0] phase_oh,
    output logic       busy,
    output logic       cpu_clk_en,
    output logic       io_pwr_good,
    output logic       active_pwr
);

    localparam int MAX_A   = (FLUSH_CYC > PRST_CYC) ? FLUSH_CYC : PRST_CYC;
    localparam int MAX_B   = (COFF_CYC > RAMP_CYC) ? COFF_CYC : RAMP_CYC;
    localparam int MAX_C   = (STAB_CYC > BOOT_CYC) ? STAB_CYC : BOOT_CYC;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CW      = (MAX_ALL > 1) ? $clog2(MAX_ALL) : 1;

    pms_state_e    state;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          in_entry;
    logic          held_clr;
    logic          wake_held;
    pms_status_t   status;

    pms_ctrl #(
        .CW(CW), .FLUSH_CYC(FLUSH_CYC), .PRST_CYC(PRST_CYC), .COFF_CYC(COFF_CYC),
        .RAMP_CYC(RAMP_CYC), .STAB_CYC(STAB_CYC), .BOOT_CYC(BOOT_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_sleep(req_sleep),
        .wake(wake), .wake_held(wake_held), .tmr_done(tmr_done), .state(state),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .in_entry(in_entry), .held_clr(held_clr)
    );

    pms_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    pms_wake_hold u_hold (
        .clk(clk), .rst_n(rst_n), .wake(wake), .in_entry(in_entry),
        .clr(held_clr), .held(wake_held)
    );

    pms_out_decode u_dec (
        .state(state), .mode(mode), .phase_oh(phase_oh), .status(status)
    );

    // Purpose: expose the decoded status flags on the ports.
    always_comb begin
        busy        = status.busy;
        cpu_clk_en  = status.clk_en;
        io_pwr_good = status.io_good;
        active_pwr  = status.active;
    end

endmodule

// File: rtl/pms_checker.sv
// Module: port-level temporal checks for pwr_mode_seq, bound below.
// Assumes the phase bit order flush, reset, clock-off, ramp, stabilise, boot.
module pms_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_idle,
    input logic       req_sleep,
    input logic       wake,
    input logic [1:0] mode,
    input logic [5:0] phase_oh,
    input logic       busy,
    input logic       cpu_clk_en,
    input logic       io_pwr_good,
    input logic       active_pwr
);

    a_r1_reset_run: assert property (@(posedge clk) $rose(rst_n) |-> (mode == 2'd0 && !busy));

    a_r2_idle_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && req_idle && !req_sleep) |=> (mode == 2'd1 && !cpu_clk_en && io_pwr_good));

    a_r3_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && wake) |=> (mode == 2'd0));

    a_r4_flush_next: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |=> (phase_oh[0] || phase_oh[1]));
    a_r4_prst_next: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[1] |=> (phase_oh[1] || phase_oh[2]));
    a_r4_coff_next: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[2] |=> (phase_oh[2] || mode == 2'd2));

    a_r5_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!cpu_clk_en && !io_pwr_good && !active_pwr));

    a_r6_ramp_next: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[3] |=> (phase_oh[3] || phase_oh[4]));
    a_r6_stab_next: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[4] |=> (phase_oh[4] || phase_oh[5]));
    a_r6_boot_next: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[5] |=> (phase_oh[5] || mode == 2'd0));

    a_r7_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(phase_oh));
    a_r7_busy_active: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (active_pwr && mode == 2'd3 && phase_oh != 6'd0));

    a_r8_no_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !phase_oh[5]) |=> (mode != 2'd1));

    a_r10_clk_phases: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[2] || phase_oh[3] || phase_oh[4]) |-> !cpu_clk_en);

endmodule

bind pwr_mode_seq pms_checker u_pms_checker (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_sleep(req_sleep),
    .wake(wake), .mode(mode), .phase_oh(phase_oh), .busy(busy),
    .cpu_clk_en(cpu_clk_en), .io_pwr_good(io_pwr_good), .active_pwr(active_pwr)
);

// File: tb/tb_pwr_mode_seq.sv
// Bench: walks a per-cycle vector table, then runs directed reset and
// long-sleep tests. Phase lengths: flush 2, reset 2, clock-off 2,
// ramp 3, stabilise 4, boot 2.
module tb_pwr_mode_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_idle = 1'b0;
    logic       req_sleep = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] mode;
    logic [5:0] phase_oh;
    logic       busy, cpu_clk_en, io_pwr_good, active_pwr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_seq #(
        .FLUSH_CYC(2), .PRST_CYC(2), .COFF_CYC(2),
        .RAMP_CYC(3), .STAB_CYC(4), .BOOT_CYC(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_sleep(req_sleep),
        .wake(wake), .mode(mode), .phase_oh(phase_oh), .busy(busy),
        .cpu_clk_en(cpu_clk_en), .io_pwr_good(io_pwr_good), .active_pwr(active_pwr)
    );

    // Row: {req tag[4], {idle,sleep,wake}[3], mode[2], phase[6], {busy,clk,io,act}[4]}
    // The result is the one seen just after the edge that samples the inputs.
    localparam int NV = 41;
    localparam logic [18:0] VEC [NV] = '{
        19'b0010_100_01_000000_0010, // R2 enter idle
        19'b0010_000_01_000000_0010, // R2 stay idle
        19'b0011_001_00_000000_0111, // R3 wake from idle, no phase
        19'b0100_010_11_000001_1111, // R4 flush 1
        19'b1000_100_11_000001_1111, // R8 idle ignored, flush 2
        19'b0100_000_11_000010_1111, // R4 reset 1
        19'b1000_010_11_000010_1111, // R8 sleep ignored, reset 2
        19'b1010_000_11_000100_1011, // R10 clock-off 1
        19'b0100_000_11_000100_1011, // R4 clock-off 2
        19'b0101_000_10_000000_0000, // R5 asleep
        19'b0101_000_10_000000_0000, // R5 still asleep
        19'b0110_001_11_001000_1001, // R6 ramp 1
        19'b1000_100_11_001000_1001, // R8 ramp 2
        19'b1010_000_11_001000_1001, // R10 ramp 3
        19'b0110_000_11_010000_1011, // R6 stab 1
        19'b0110_000_11_010000_1011, // R6 stab 2
        19'b1000_010_11_010000_1011, // R8 stab 3
        19'b0110_000_11_010000_1011, // R6 stab 4
        19'b1010_000_11_100000_1111, // R10 boot 1
        19'b0111_000_11_100000_1111, // R7 boot 2
        19'b0110_000_00_000000_0111, // R6 back in run
        19'b0010_110_11_000001_1111, // R2 sleep beats idle
        19'b1001_001_11_000001_1111, // R9 wake during flush held
        19'b0100_000_11_000010_1111, // R4
        19'b0100_000_11_000010_1111, // R4
        19'b0100_000_11_000100_1011, // R4
        19'b0100_000_11_000100_1011, // R4
        19'b1001_000_10_000000_0000, // R9 single sleep cycle
        19'b1001_000_11_001000_1001, // R9 exit without new wake
        19'b0110_000_11_001000_1001, // R6
        19'b0110_000_11_001000_1001, // R6
        19'b0110_000_11_010000_1011, // R6
        19'b0110_000_11_010000_1011, // R6
        19'b0110_000_11_010000_1011, // R6
        19'b0110_000_11_010000_1011, // R6
        19'b0110_000_11_100000_1111, // R6
        19'b0110_000_11_100000_1111, // R6
        19'b0110_000_00_000000_0111, // R6 run
        19'b0010_100_01_000000_0010, // R2 idle again
        19'b0011_011_00_000000_0111, // R3 wake beats sleep in idle
        19'b0011_001_00_000000_0111  // R3 wake in run has no effect
    };

    task automatic check(input int tag, input logic [11:0] expv);
        logic [11:0] actv;
        actv = {mode, phase_oh, busy, cpu_clk_en, io_pwr_good, active_pwr};
        checks++;
        if (actv !== expv) begin
            fails++;
            $display("FAIL R%0d at %0t: actual %b expected %b", tag, $time, actv, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        rst_n = 1'b1;
        check(1, {2'd0, 6'b000000, 4'b0111});

        for (int i = 0; i < NV; i++) begin
            {req_idle, req_sleep, wake} = VEC[i][14:12];
            tick();
            check(int'(VEC[i][18:15]), VEC[i][11:0]);
        end
        {req_idle, req_sleep, wake} = 3'b000;

        // R11: reset in the middle of the flush phase
        req_sleep = 1'b1;
        tick();
        req_sleep = 1'b0;
        check(4, {2'd3, 6'b000001, 4'b1111});
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check(11, {2'd0, 6'b000000, 4'b0111});

        // R5 / R9: a long sleep with no wake stays asleep (held wake consumed)
        req_sleep = 1'b1;
        tick();
        req_sleep = 1'b0;
        repeat (6) tick();
        check(5, {2'd2, 6'b000000, 4'b0000});
        repeat (20) tick();
        check(9, {2'd2, 6'b000000, 4'b0000});
        wake = 1'b1;
        tick();
        wake = 1'b0;
        check(6, {2'd3, 6'b001000, 4'b1001});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule